// File: doc/BRIEF.md
# Mirrored Shader Code Upload Port

This block loads instruction words and operand-descriptor (swizzle) words into the memories of two shader units, a primary unit and a secondary unit. A host drives a plain register write bus. Each of the four memory streams has a window of eight neighbouring data addresses, and all eight do the same thing. Every data write stores one 32-bit word at the stream's current offset, and that offset then steps by one. The host can therefore stream a whole program through one address or through any mix of the eight.

By default the secondary unit shadows the primary one. A word accepted by a primary stream is also written into the matching secondary memory, at the same offset. Setting an exclusivity bit in a configuration register turns this copy off, so the secondary unit can hold code of its own. Writes made through the secondary unit's own windows never travel back to the primary unit.

Every stream has a depth limit. A write that arrives when the offset is already at or past that limit is dropped and raises a sticky error flag for that stream. For inspection, each memory has its own read port, and a register read port returns the offsets, the configuration bit and the error flags.

Top module: `shader_code_loader`

## Requirements
- R1: A write to any of the eight data addresses of a stream stores the word at that stream's current offset. The offset then rises by one. The data windows are 0x29C–0x2A3 (secondary program), 0x2A6–0x2AD (secondary swizzle), 0x2CC–0x2D3 (primary program) and 0x2D6–0x2DD (primary swizzle).
- R2: The address one below each data window holds that stream's offset register (0x29B, 0x2A5, 0x2CB, 0x2D5). Writing it loads bits 15:0 of the data as the new offset. Reading it on the read port returns the offset, zero-extended.
- R3: The primary program memory holds 512 words, the secondary program memory 4096 and each swizzle memory 1024. A data write made when the offset is at or beyond the depth changes no memory and leaves the offset unchanged. It also sets that stream's error flag. The error flag bits are: bit 0 secondary program, bit 1 secondary swizzle, bit 2 primary program, bit 3 primary swizzle.
- R4: While bit 0 of the configuration register at 0x244 is 0, every accepted primary program write is also written into secondary program memory at the same offset. Primary swizzle writes are copied into secondary swizzle memory in the same way. The copy does not move the secondary stream's offset.
- R5: While configuration bit 0 is 1, primary writes change only the primary memories, and the secondary memory contents stay as they were.
- R6: Writes through the secondary unit's data windows never change primary memory or primary offsets.
- R7: Error flags stay set until the host writes the status register at 0x2E0 with a 1 in the flag's bit position. A 0 in that position leaves the flag as it is. The flags read back at 0x2E0 and on `err_flags`.
- R8: After reset all offsets, the configuration bit and all error flags are zero.
- R9: Data writes on consecutive clock cycles land at consecutive offsets, because each write already sees the offset left by the write before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 10 | Register read address |
| rd_data | output | 32 | Register read data (offsets, configuration, flags) |
| err_flags | output | 4 | Sticky per-stream error flags |
| sec_prog_raddr | input | 12 | Secondary program memory read address |
| sec_prog_rdata | output | 32 | Secondary program memory read data |
| sec_swz_raddr | input | 10 | Secondary swizzle memory read address |
| sec_swz_rdata | output | 32 | Secondary swizzle memory read data |
| pri_prog_raddr | input | 9 | Primary program memory read address |
| pri_prog_rdata | output | 32 | Primary program memory read data |
| pri_swz_raddr | input | 10 | Primary swizzle memory read address |
| pri_swz_rdata | output | 32 | Primary swizzle memory read data |

## Verification
Some properties are checked on every cycle. An accepted write advances the offset by exactly one, and a write past the depth freezes the offset and raises the flag. An offset load takes the bus value, and an error flag never drops without a clear. On the memory side, a copy happens exactly when the exclusivity bit is clear, and no secondary-window write ever reaches a primary memory. Other behaviour shows only in the bench scenarios, because only there can the stored values be read back and compared with an independent model. That covers the words held at each offset and the alias equivalence across all eight addresses. It also covers unchanged secondary contents under exclusivity, and the interplay of random offset loads, overflows and partial flag clears.

// File: rtl/shl_pkg.sv
package shl_pkg;

   localparam int unsigned N_STREAMS  = 4;
   localparam int unsigned S_SEC_PROG = 0;
   localparam int unsigned S_SEC_SWZ  = 1;
   localparam int unsigned S_PRI_PROG = 2;
   localparam int unsigned S_PRI_SWZ  = 3;

   localparam int unsigned CFG_ADDR   = 32'h244;
   localparam int unsigned STAT_ADDR  = 32'h2E0;

   // first data address of each stream window; offset register sits one below
   function automatic int unsigned stream_base(input int unsigned s);
      case (s)
         S_SEC_PROG: return 32'h29C;
         S_SEC_SWZ:  return 32'h2A6;
         S_PRI_PROG: return 32'h2CC;
         default:    return 32'h2D6;
      endcase
   endfunction

endpackage

// File: rtl/shl_decode.sv
module shl_decode
   import shl_pkg::*;
#(
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned N_ALIAS = 8
) (
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   output logic [N_STREAMS-1:0] data_hit,
   output logic [N_STREAMS-1:0] load_hit,
   output logic                 cfg_hit,
   output logic                 clr_hit
);

   initial begin
      assert (stream_base(S_PRI_SWZ) + N_ALIAS <= (1 << ADDR_W))
         else $error("address width too small for stream windows");
      assert (STAT_ADDR < (1 << ADDR_W))
         else $error("address width too small for status register");
   end

   for (genvar s = 0; s < N_STREAMS; s++) begin : g_win
      localparam logic [ADDR_W-1:0] LO = ADDR_W'(stream_base(s));
      localparam logic [ADDR_W-1:0] HI = ADDR_W'(stream_base(s) + N_ALIAS - 1);
      localparam logic [ADDR_W-1:0] LD = ADDR_W'(stream_base(s) - 1);
      assign data_hit[s] = wr_en && (wr_addr >= LO) && (wr_addr <= HI);
      assign load_hit[s] = wr_en && (wr_addr == LD);
   end

   assign cfg_hit = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));
   assign clr_hit = wr_en && (wr_addr == ADDR_W'(STAT_ADDR));

endmodule

// File: rtl/shl_stream.sv
module shl_stream #(
   parameter int unsigned DEPTH = 512,
   parameter int unsigned OFF_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_hit,
   input  logic             load_hit,
   input  logic             clr,
   input  logic [OFF_W-1:0] load_val,
   output logic [OFF_W-1:0] offset,
   output logic             err,
   output logic             accept
);

   localparam logic [OFF_W-1:0] LIMIT = OFF_W'(DEPTH);

   initial begin
      assert (DEPTH > 1 && DEPTH < (1 << OFF_W))
         else $error("stream depth does not fit the offset width");
   end

   logic [OFF_W-1:0] off_q;
   logic             err_q;

   assign accept = data_hit && (off_q < LIMIT);
   assign offset = off_q;
   assign err    = err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_q <= '0;
         err_q <= 1'b0;
      end else begin
         if (load_hit)
            off_q <= load_val;
         else if (accept)
            off_q <= off_q + 1'b1;
         if (data_hit && !accept)
            err_q <= 1'b1;
         else if (clr)
            err_q <= 1'b0;
      end
   end

   // R1: accepted write advances offset by one
   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> offset == OFF_W'($past(offset) + 1'b1));

   // R3: write at or past depth is dropped and flagged
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (data_hit && offset >= LIMIT) |=> ($stable(offset) && err));

   // R2: offset load takes bus value
   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_hit |=> offset == $past(load_val));

   // R7: flag is sticky until cleared
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr) |=> err);

endmodule

// File: rtl/shl_ram.sv
module shl_ram #(
   parameter int unsigned DEPTH  = 512,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   assign rdata = (32'(raddr) < DEPTH) ? mem[raddr] : '0;

endmodule

// File: rtl/shader_code_loader.sv
module shader_code_loader
   import shl_pkg::*;
#(
   parameter int unsigned ADDR_W         = 10,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned N_ALIAS        = 8,
   parameter int unsigned PRI_PROG_DEPTH = 512,
   parameter int unsigned SEC_PROG_DEPTH = 4096,
   parameter int unsigned SWZ_DEPTH      = 1024,
   parameter int unsigned OFF_W          = 16,
   parameter bit          MIRROR_EN      = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [DATA_W-1:0]                 wr_data,
   input  logic [ADDR_W-1:0]                 rd_addr,
   output logic [DATA_W-1:0]                 rd_data,
   output logic [N_STREAMS-1:0]              err_flags,
   input  logic [$clog2(SEC_PROG_DEPTH)-1:0] sec_prog_raddr,
   output logic [DATA_W-1:0]                 sec_prog_rdata,
   input  logic [$clog2(SWZ_DEPTH)-1:0]      sec_swz_raddr,
   output logic [DATA_W-1:0]                 sec_swz_rdata,
   input  logic [$clog2(PRI_PROG_DEPTH)-1:0] pri_prog_raddr,
   output logic [DATA_W-1:0]                 pri_prog_rdata,
   input  logic [$clog2(SWZ_DEPTH)-1:0]      pri_swz_raddr,
   output logic [DATA_W-1:0]                 pri_swz_rdata
);

   localparam int unsigned SP_AW = $clog2(SEC_PROG_DEPTH);
   localparam int unsigned PP_AW = $clog2(PRI_PROG_DEPTH);
   localparam int unsigned SW_AW = $clog2(SWZ_DEPTH);

   initial begin
      assert (PRI_PROG_DEPTH <= SEC_PROG_DEPTH)
         else $error("secondary program memory must cover the primary one");
      assert (DATA_W >= OFF_W && DATA_W >= N_STREAMS)
         else $error("data width too narrow");
   end

   // ---------------- decode ----------------
   logic [N_STREAMS-1:0] data_hit, load_hit, accept, err_q;
   logic                 cfg_hit, clr_hit;
   logic [OFF_W-1:0]     off_q [N_STREAMS];

   shl_decode #(.ADDR_W(ADDR_W), .N_ALIAS(N_ALIAS)) u_dec (
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .data_hit (data_hit),
      .load_hit (load_hit),
      .cfg_hit  (cfg_hit),
      .clr_hit  (clr_hit)
   );

   // ---------------- offset streams ----------------
   for (genvar s = 0; s < N_STREAMS; s++) begin : g_str
      localparam int unsigned D = (s == S_PRI_PROG) ? PRI_PROG_DEPTH :
                                  (s == S_SEC_PROG) ? SEC_PROG_DEPTH : SWZ_DEPTH;
      shl_stream #(.DEPTH(D), .OFF_W(OFF_W)) u_str (
         .clk      (clk),
         .rst_n    (rst_n),
         .data_hit (data_hit[s]),
         .load_hit (load_hit[s]),
         .clr      (clr_hit && wr_data[s]),
         .load_val (wr_data[OFF_W-1:0]),
         .offset   (off_q[s]),
         .err      (err_q[s]),
         .accept   (accept[s])
      );
   end

   assign err_flags = err_q;

   // ---------------- configuration ----------------
   logic excl_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         excl_q <= 1'b0;
      else if (cfg_hit)
         excl_q <= wr_data[0];
   end

   logic mirror_on;
   if (MIRROR_EN) begin : g_mirror
      assign mirror_on = !excl_q;
   end else begin : g_nomirror
      assign mirror_on = 1'b0;
   end

   // ---------------- memory write paths ----------------
   logic             pp_we, ps_we, sp_we, ss_we;
   logic [PP_AW-1:0] pp_waddr;
   logic [SW_AW-1:0] ps_waddr, ss_waddr;
   logic [SP_AW-1:0] sp_waddr;

   assign pp_we    = accept[S_PRI_PROG];
   assign pp_waddr = PP_AW'(off_q[S_PRI_PROG]);
   assign ps_we    = accept[S_PRI_SWZ];
   assign ps_waddr = SW_AW'(off_q[S_PRI_SWZ]);

   assign sp_we    = accept[S_SEC_PROG] || (mirror_on && accept[S_PRI_PROG]);
   assign sp_waddr = accept[S_SEC_PROG] ? SP_AW'(off_q[S_SEC_PROG])
                                        : SP_AW'(off_q[S_PRI_PROG]);
   assign ss_we    = accept[S_SEC_SWZ] || (mirror_on && accept[S_PRI_SWZ]);
   assign ss_waddr = accept[S_SEC_SWZ] ? SW_AW'(off_q[S_SEC_SWZ])
                                       : SW_AW'(off_q[S_PRI_SWZ]);

   shl_ram #(.DEPTH(PRI_PROG_DEPTH), .DATA_W(DATA_W)) u_pri_prog (
      .clk(clk), .we(pp_we), .waddr(pp_waddr), .wdata(wr_data),
      .raddr(pri_prog_raddr), .rdata(pri_prog_rdata));

   shl_ram #(.DEPTH(SWZ_DEPTH), .DATA_W(DATA_W)) u_pri_swz (
      .clk(clk), .we(ps_we), .waddr(ps_waddr), .wdata(wr_data),
      .raddr(pri_swz_raddr), .rdata(pri_swz_rdata));

   shl_ram #(.DEPTH(SEC_PROG_DEPTH), .DATA_W(DATA_W)) u_sec_prog (
      .clk(clk), .we(sp_we), .waddr(sp_waddr), .wdata(wr_data),
      .raddr(sec_prog_raddr), .rdata(sec_prog_rdata));

   shl_ram #(.DEPTH(SWZ_DEPTH), .DATA_W(DATA_W)) u_sec_swz (
      .clk(clk), .we(ss_we), .waddr(ss_waddr), .wdata(wr_data),
      .raddr(sec_swz_raddr), .rdata(sec_swz_rdata));

   // ---------------- register read port ----------------
   always_comb begin
      rd_data = '0;
      for (int s = 0; s < N_STREAMS; s++) begin
         if (rd_addr == ADDR_W'(stream_base(s) - 1))
            rd_data = DATA_W'(off_q[s]);
      end
      if (rd_addr == ADDR_W'(CFG_ADDR))
         rd_data = DATA_W'(excl_q);
      if (rd_addr == ADDR_W'(STAT_ADDR))
         rd_data = DATA_W'(err_q);
   end

   // R4: shared mode copies primary program writes at the same offset
   a_r4_mirror_prog: assert property (@(posedge clk) disable iff (!rst_n)
      (MIRROR_EN && !excl_q && data_hit[S_PRI_PROG] && accept[S_PRI_PROG]) |->
         (sp_we && 32'(sp_waddr) == 32'(off_q[S_PRI_PROG])));

   // R4: shared mode copies primary swizzle writes at the same offset
   a_r4_mirror_swz: assert property (@(posedge clk) disable iff (!rst_n)
      (MIRROR_EN && !excl_q && accept[S_PRI_SWZ]) |->
         (ss_we && 32'(ss_waddr) == 32'(off_q[S_PRI_SWZ])));

   // R5: exclusive mode keeps secondary memories out of primary writes
   a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (excl_q && (data_hit[S_PRI_PROG] || data_hit[S_PRI_SWZ])) |-> (!sp_we && !ss_we));

   // R6: secondary window writes never reach primary memories or offsets
   a_r6_one_way: assert property (@(posedge clk) disable iff (!rst_n)
      (data_hit[S_SEC_PROG] || data_hit[S_SEC_SWZ]) |=>
         ($stable(off_q[S_PRI_PROG]) && $stable(off_q[S_PRI_SWZ])));

   a_r6_no_pri_we: assert property (@(posedge clk) disable iff (!rst_n)
      (data_hit[S_SEC_PROG] || data_hit[S_SEC_SWZ]) |-> (!pp_we && !ps_we));

endmodule

// File: tb/sim_shader_code_loader.sv
`timescale 1ns/100ps
module sim_shader_code_loader;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [9:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [9:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [3:0]  err_flags;
   logic [11:0] sec_prog_raddr = '0;
   logic [31:0] sec_prog_rdata;
   logic [9:0]  sec_swz_raddr = '0;
   logic [31:0] sec_swz_rdata;
   logic [8:0]  pri_prog_raddr = '0;
   logic [31:0] pri_prog_rdata;
   logic [9:0]  pri_swz_raddr = '0;
   logic [31:0] pri_swz_rdata;

   shader_code_loader u0 (.*);

   always #2 clk = ~clk;

   int total = 0;
   int bad = 0;

   localparam int BASE [4]  = '{'h29C, 'h2A6, 'h2CC, 'h2D6};
   localparam int DEPTH [4] = '{4096, 1024, 512, 1024};
   localparam int CFG  = 'h244;
   localparam int STAT = 'h2E0;

   int          m_off [4];
   logic [3:0]  m_err;
   logic        m_excl;
   logic [31:0] m_sec [2][int];

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 10'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_reg(int a, output logic [31:0] v);
      rd_addr = 10'(a);
      #0.1;
      v = rd_data;
   endtask

   task automatic rd_mem(int s, int o, output logic [31:0] v);
      case (s)
         0: begin sec_prog_raddr = 12'(o); #0.1; v = sec_prog_rdata; end
         1: begin sec_swz_raddr  = 10'(o); #0.1; v = sec_swz_rdata;  end
         2: begin pri_prog_raddr = 9'(o);  #0.1; v = pri_prog_rdata; end
         default: begin pri_swz_raddr = 10'(o); #0.1; v = pri_swz_rdata; end
      endcase
   endtask

   // model of one data write; returns checks on memory, offset and flags
   task automatic model_data(int s, int alias_i, logic [31:0] d);
      logic [31:0] v;
      int o;
      logic [31:0] old;
      logic had_old;
      o = m_off[s];
      had_old = 1'b0;
      old = '0;
      if (s >= 2 && m_sec[s-2].exists(o)) begin had_old = 1'b1; old = m_sec[s-2][o]; end
      wr(BASE[s] + alias_i, d);
      if (o < DEPTH[s]) begin
         m_off[s] = o + 1;
         rd_mem(s, o, v);
         check("R1 stored word", v, d);
         if (s < 2) m_sec[s][o] = d;
         else if (!m_excl) begin
            rd_mem(s - 2, o, v);
            check("R4 mirrored word", v, d);
            m_sec[s-2][o] = d;
         end else if (had_old) begin
            rd_mem(s - 2, o, v);
            check("R5 secondary unchanged", v, old);
         end
      end else begin
         m_err[s] = 1'b1;
      end
      rd_reg(BASE[s] - 1, v);
      check("R1/R3 offset after write", v, 32'(m_off[s]));
      check("R3 error flags", 32'(err_flags), 32'(m_err));
   endtask

   initial begin
      #(4 * 150000);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'h1234_5eed));
      for (int i = 0; i < 4; i++) m_off[i] = 0;
      m_err = '0;
      m_excl = 1'b0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 reset state
      for (int s = 0; s < 4; s++) begin
         rd_reg(BASE[s] - 1, v);
         check("R8 offset reset", v, 32'd0);
      end
      rd_reg(CFG, v);  check("R8 config reset", v, 32'd0);
      rd_reg(STAT, v); check("R8 flags reset", v, 32'd0);

      // R1 + R9: back-to-back burst through all eight primary program aliases
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         wr_en = 1'b1; wr_addr = 10'(BASE[2] + i); wr_data = 32'hA000_0000 + i;
         @(negedge clk);
      end
      wr_en = 1'b0;
      for (int i = 0; i < 8; i++) begin
         rd_mem(2, i, v); check("R9 burst alias word", v, 32'hA000_0000 + i);
         rd_mem(0, i, v); check("R4 burst mirrored", v, 32'hA000_0000 + i);
         m_sec[0][i] = 32'hA000_0000 + i;
      end
      m_off[2] = 8;
      rd_reg(BASE[2] - 1, v); check("R9 offset after burst", v, 32'd8);
      rd_reg(BASE[0] - 1, v); check("R4 secondary offset untouched", v, 32'd0);

      // R6: secondary write at offset 0 leaves primary alone
      model_data(0, 3, 32'h5EC0_0001);
      rd_mem(2, 0, v); check("R6 primary unchanged", v, 32'hA000_0000);
      rd_reg(BASE[2] - 1, v); check("R6 primary offset", v, 32'd8);

      // R5: exclusive mode, primary write at 0 leaves secondary word
      wr(CFG, 32'h1); m_excl = 1'b1;
      rd_reg(CFG, v); check("R5 config readback", v, 32'd1);
      wr(BASE[2] - 1, 32'd0); m_off[2] = 0;
      rd_reg(BASE[2] - 1, v); check("R2 offset load", v, 32'd0);
      model_data(2, 7, 32'hBEEF_0002);
      rd_mem(0, 0, v); check("R5 secondary kept", v, 32'h5EC0_0001);

      // R3: primary program limit 512
      wr(BASE[2] - 1, 32'd511); m_off[2] = 511;
      model_data(2, 0, 32'h0000_01FF);
      model_data(2, 1, 32'hDEAD_DEAD);
      check("R3 primary flag bit2", 32'(err_flags[2]), 32'd1);
      // secondary program limit 4096
      wr(BASE[0] - 1, 32'd4095); m_off[0] = 4095;
      model_data(0, 5, 32'h0000_0FFF);
      model_data(0, 6, 32'h1111_2222);
      check("R3 secondary flag bit0", 32'(err_flags[0]), 32'd1);

      // R7: partial clears
      wr(STAT, 32'h1); m_err[0] = 1'b0;
      rd_reg(STAT, v); check("R7 partial clear", v, 32'(m_err));
      wr(STAT, 32'h0);
      rd_reg(STAT, v); check("R7 zero keeps flag", v, 32'h4);
      wr(STAT, 32'h4); m_err[2] = 1'b0;
      rd_reg(STAT, v); check("R7 full clear", v, 32'd0);

      // R4: swizzle mirror in shared mode
      wr(CFG, 32'h0); m_excl = 1'b0;
      wr(BASE[3] - 1, 32'd5); m_off[3] = 5;
      model_data(3, 2, 32'h5A5A_0005);
      rd_mem(1, 5, v); check("R4 swizzle mirror", v, 32'h5A5A_0005);

      // random mix
      for (int it = 0; it < 600; it++) begin
         int r;
         int s;
         r = int'($urandom % 16);
         s = int'($urandom % 4);
         if (r == 0) begin
            m_excl = 1'($urandom);
            wr(CFG, 32'(m_excl));
            rd_reg(CFG, v); check("R4/R5 config", v, 32'(m_excl));
         end else if (r == 1) begin
            int o;
            o = ($urandom % 2 == 0) ? DEPTH[s] - 2 + int'($urandom % 4)
                                    : int'($urandom % DEPTH[s]);
            wr(BASE[s] - 1, 32'(o)); m_off[s] = o;
            rd_reg(BASE[s] - 1, v); check("R2 random load", v, 32'(o));
         end else if (r == 2) begin
            logic [3:0] c;
            c = 4'($urandom);
            wr(STAT, 32'(c)); m_err = m_err & ~c;
            rd_reg(STAT, v); check("R7 random clear", v, 32'(m_err));
         end else begin
            model_data(s, int'($urandom % 8), $urandom);
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule